// File: doc/BRIEF.md
# Sound Coprocessor I/O Register Decoder

This block sits beside the CPU of an 8-bit sound coprocessor and serves the small I/O window at the top of page zero. The window runs from 0x00F0 to 0x00FF. On every access the block decodes the CPU's read and write strobes, its 16-bit address and its write data. Read data comes back in the same cycle. It is taken from one of three places: the block's own registers, a 64-byte boot ROM that can overlay the top of memory, or the external RAM byte that the CPU supplies on `ram_rdata`.

The registers are:
- a test register that sets the clock speeds, the timer gating and RAM write permission;
- a control register that enables the timers, clears mailbox ports and maps the boot ROM in or out;
- an index and data pair that reaches the DSP register file;
- four mailbox ports shared with a host CPU;
- two scratch bytes;
- three timer target bytes.

Each mailbox port holds two latches at one address. One latch is written by the host and read by the CPU. The other is written by the CPU and read by the host through `host_addr`.

The timers, the DSP and the CPU core are outside this block. Toward them the block only presents enables, targets, strobes and read pulses.

Top module: `snd_io_decoder`

## Requirements
- R1: Addresses whose bits [15:4] equal 0x00F select the register window. Reads there return register values and never `ram_rdata`. Reads at any other address that the boot ROM does not cover return `ram_rdata`.
- R2: While the ROM-map flag is 1, a read at 0xFFC0–0xFFFF returns boot byte i, where i = addr[5:0] and the byte equals (i*29 mod 256) XOR 0x5A. While the flag is 0, those addresses read RAM.
- R3: Reads of 0x00F0, 0x00F1, 0x00FA, 0x00FB and 0x00FC return 0x00.
- R4: A write to 0x00F2 sets the DSP index, and a read of 0x00F2 returns it. `dsp_addr` carries index[6:0], and a read of 0x00F3 returns `dsp_rdata`. A write to 0x00F3 raises `dsp_we` only when index bit 7 is 0.
- R5: A CPU read of 0x00F4+k returns the byte the host last wrote to port k. A CPU write to 0x00F4+k sets outgoing latch k, which appears on `host_rdata` when `host_addr` = k.
- R6: A write to 0x00F1 acts on several things at once:
  - Bit 4 clears host-written ports 0 and 1, and bit 5 clears ports 2 and 3. A clear wins over a host write in the same cycle.
  - Bits 2:0 become `tmr_en`.
  - Bit 7 becomes the ROM-map flag.
- R7: A write to 0x00F0 while `dp_flag` is 1 changes nothing. When `dp_flag` is 0, the write decodes its fields as follows:
  - bits 7:6 go to `int_speed`;
  - bits 5:4 go to `ext_speed`;
  - bit 3 is timer-run;
  - bit 1 is RAM write permit;
  - bit 0 is timer-halt.
- R8: `tmr_global_en` is 1 exactly when timer-run is 1 and timer-halt is 0.
- R9: Writes to 0x00FA–0x00FC load target bytes 0–2, and target n occupies `tmr_target` bits [8n+7:8n]. A read of 0x00FD+n returns `tmr_count` byte n and raises `tmr_rd_pulse[n]` for that cycle only.
- R10: 0x00F8 and 0x00F9 are scratch bytes that read back the last value written.
- R11: `ram_we` follows `cpu_wr` whenever RAM write permit is 1, at any address including the register window. The permit value in force before the write is the one used.
- R12: After reset the following values hold:
  - the outgoing latches, host-written latches, scratch bytes, targets, DSP index, `tmr_en` and speeds are all 0;
  - the ROM-map flag, timer-run and write permit are 1;
  - timer-halt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Combinational read data |
| dp_flag | input | 1 | CPU direct-page flag; blocks test-register writes |
| ram_rdata | input | 8 | RAM byte at `cpu_addr` |
| ram_we | output | 1 | Write-through strobe to RAM (data is `cpu_wdata`) |
| dsp_addr | output | 7 | DSP register index, low seven bits |
| dsp_rdata | input | 8 | DSP register value at `dsp_addr` |
| dsp_we | output | 1 | DSP register write strobe (data is `cpu_wdata`) |
| host_wr | input | 1 | Host mailbox write strobe |
| host_addr | input | 2 | Host mailbox port select |
| host_wdata | input | 8 | Host mailbox write data |
| host_rdata | output | 8 | Outgoing latch selected by `host_addr` |
| tmr_target | output | 24 | Three timer target bytes |
| tmr_en | output | 3 | Per-timer enables |
| tmr_global_en | output | 1 | Global timer gate |
| tmr_count | input | 24 | Three timer output counters |
| tmr_rd_pulse | output | 3 | Counter-read pulse per timer |
| int_speed | output | 2 | Internal wait-speed field |
| ext_speed | output | 2 | External wait-speed field |

## Verification
The bench targets the following corner cases:
- The two latches behind each mailbox address. A design that shared one latch would hand the CPU's own write back to the CPU.
- A port clear that arrives in the same cycle as a host write to that port. Letting the host win would leave stale mailbox data after a clear.
- A test-register write while `dp_flag` is set. Accepting it would silently change the speeds and the timer gate.
- A DSP data write with index bit 7 set. A missing guard would corrupt DSP register index & 0x7F.
- A write made just after write permit is dropped. Using the new permit rather than the old one would skip or add a RAM write.
- Boot ROM reads before and after the ROM-map flag is cleared. A wrong overlay returns ROM bytes in place of RAM, or the reverse.

// File: rtl/snd_io_decoder.sv
module snd_io_decoder #(
  parameter logic [7:0] ROM_MUL = 8'd29,
  parameter logic [7:0] ROM_XOR = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  input  logic        dp_flag,
  input  logic [7:0]  ram_rdata,
  output logic        ram_we,
  output logic [6:0]  dsp_addr,
  input  logic [7:0]  dsp_rdata,
  output logic        dsp_we,
  input  logic        host_wr,
  input  logic [1:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic [23:0] tmr_target,
  output logic [2:0]  tmr_en,
  output logic        tmr_global_en,
  input  logic [23:0] tmr_count,
  output logic [2:0]  tmr_rd_pulse,
  output logic [1:0]  int_speed,
  output logic [1:0]  ext_speed
);
  localparam int NTMR = 3;

  logic [3:0][7:0]      in_q, out_q;
  logic [1:0][7:0]      scr_q;
  logic [NTMR-1:0][7:0] tgt_q;
  logic [7:0]           idx_q;
  logic [2:0]           ten_q;
  logic                 rom_q, wen_q, run_q, halt_q;
  logic [1:0]           is_q, es_q;
  logic [7:0]           io_rd;

  wire       io_sel  = cpu_addr[15:4] == 12'h00F;
  wire       rom_sel = rom_q & (&cpu_addr[15:6]);
  wire [3:0] ra      = cpu_addr[3:0];
  wire       io_wr   = cpu_wr & io_sel;

  function automatic logic [7:0] boot_byte(input logic [5:0] i);
    logic [15:0] p;
    p = {10'd0, i} * {8'd0, ROM_MUL};
    return p[7:0] ^ ROM_XOR;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= '0; out_q <= '0; scr_q <= '0; tgt_q <= '0;
      idx_q <= '0; ten_q <= '0; is_q <= '0; es_q <= '0;
      rom_q <= 1'b1; wen_q <= 1'b1; run_q <= 1'b1; halt_q <= 1'b0;
    end else begin
      if (host_wr) in_q[host_addr] <= host_wdata;
      if (io_wr) begin
        case (ra)
          4'h0: if (!dp_flag) begin
            is_q   <= cpu_wdata[7:6];
            es_q   <= cpu_wdata[5:4];
            run_q  <= cpu_wdata[3];
            wen_q  <= cpu_wdata[1];
            halt_q <= cpu_wdata[0];
          end
          4'h1: begin
            if (cpu_wdata[4]) begin in_q[0] <= '0; in_q[1] <= '0; end
            if (cpu_wdata[5]) begin in_q[2] <= '0; in_q[3] <= '0; end
            ten_q <= cpu_wdata[2:0];
            rom_q <= cpu_wdata[7];
          end
          4'h2: idx_q <= cpu_wdata;
          4'h4, 4'h5, 4'h6, 4'h7: out_q[ra[1:0]] <= cpu_wdata;
          4'h8, 4'h9: scr_q[ra[0]] <= cpu_wdata;
          4'hA: tgt_q[0] <= cpu_wdata;
          4'hB: tgt_q[1] <= cpu_wdata;
          4'hC: tgt_q[2] <= cpu_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (ra)
      4'h2: io_rd = idx_q;
      4'h3: io_rd = dsp_rdata;
      4'h4, 4'h5, 4'h6, 4'h7: io_rd = in_q[ra[1:0]];
      4'h8, 4'h9: io_rd = scr_q[ra[0]];
      4'hD: io_rd = tmr_count[7:0];
      4'hE: io_rd = tmr_count[15:8];
      4'hF: io_rd = tmr_count[23:16];
      default: io_rd = 8'h00;
    endcase
  end

  assign cpu_rdata = rom_sel ? boot_byte(cpu_addr[5:0]) : io_sel ? io_rd : ram_rdata;

  for (genvar k = 0; k < NTMR; k++) begin : g_pulse
    assign tmr_rd_pulse[k] = cpu_rd & io_sel & (ra == 4'(13 + k));
  end

  assign ram_we        = cpu_wr & wen_q;
  assign dsp_we        = io_wr & (ra == 4'h3) & ~idx_q[7];
  assign dsp_addr      = idx_q[6:0];
  assign host_rdata    = out_q[host_addr];
  assign tmr_target    = tgt_q;
  assign tmr_en        = ten_q;
  assign tmr_global_en = run_q & ~halt_q;
  assign int_speed     = is_q;
  assign ext_speed     = es_q;
endmodule

// File: rtl/snd_io_decoder_chk.sv
module snd_io_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic [7:0]  cpu_rdata,
  input logic        dp_flag,
  input logic [7:0]  ram_rdata,
  input logic [6:0]  dsp_addr,
  input logic        dsp_we,
  input logic [2:0]  tmr_rd_pulse,
  input logic        tmr_global_en,
  input logic [1:0]  int_speed,
  input logic [1:0]  ext_speed
);
  assert_dsp_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h00F2) |=> dsp_addr == $past(cpu_wdata[6:0]));

  assert_dsp_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h00F2 && cpu_wdata[7]) |=> !(cpu_wr && cpu_addr == 16'h00F3 && dsp_we));

  assert_port_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h00F1 && cpu_wdata[4])
      |=> (!(cpu_rd && cpu_addr == 16'h00F4) || cpu_rdata == 8'h00));

  assert_rom_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h00F1 && !cpu_wdata[7])
      |=> (!(cpu_rd && cpu_addr >= 16'hFFC0) || cpu_rdata == ram_rdata));

  assert_test_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h00F0 && dp_flag)
      |=> ($stable(int_speed) && $stable(ext_speed) && $stable(tmr_global_en)));

  assert_halt_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h00F0 && !dp_flag && cpu_wdata[0]) |=> !tmr_global_en);

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_rd_pulse));

  assert_pulse_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_rd_pulse != 3'b000) |-> cpu_rd);
endmodule

bind snd_io_decoder snd_io_decoder_chk u_chk (.*);

// File: tb/test_snd_io_decoder.sv
`timescale 1ns/1ps
module test_snd_io_decoder;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_rd = 0, cpu_wr = 0, dp_flag = 0, host_wr = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0, ram_rdata = 0, host_wdata = 0;
  logic [1:0]  host_addr = 0;
  logic [7:0]  cpu_rdata, host_rdata, dsp_rdata;
  logic [6:0]  dsp_addr;
  logic        ram_we, dsp_we, tmr_global_en;
  logic [23:0] tmr_target;
  logic [23:0] tmr_count = 24'h332211;
  logic [2:0]  tmr_en, tmr_rd_pulse;
  logic [1:0]  int_speed, ext_speed;

  always #2.5 clk = ~clk;
  assign dsp_rdata = {1'b1, dsp_addr};

  snd_io_decoder i_snd_io_decoder (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  byte unsigned mem[int];
  int m_in[4], m_out[4], m_scr[2], m_tgt[3];
  int m_idx, m_ten, m_rom, m_wen, m_run, m_halt, m_is, m_es;

  function automatic int ramv(int a);
    if (mem.exists(a)) return mem[a];
    return (a & 255) ^ ((a >> 8) & 255);
  endfunction

  function automatic int romv(int i);
    return ((i * 29) % 256) ^ 'h5A;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_in[i]) begin m_in[i] = 0; m_out[i] = 0; end
      m_scr = '{0, 0}; m_tgt = '{0, 0, 0};
      m_idx = 0; m_ten = 0; m_is = 0; m_es = 0;
      m_rom = 1; m_wen = 1; m_run = 1; m_halt = 0;
    end else begin
      int a, d;
      a = cpu_addr; d = cpu_wdata;
      if (cpu_wr && m_wen != 0) mem[a] = byte'(d);
      if (host_wr) m_in[host_addr] = host_wdata;
      if (cpu_wr && a >= 'hF0 && a <= 'hFF) begin
        if (a == 'hF0 && !dp_flag) begin
          m_is = d >> 6; m_es = (d >> 4) & 3; m_run = (d >> 3) & 1;
          m_wen = (d >> 1) & 1; m_halt = d & 1;
        end
        if (a == 'hF1) begin
          if (d & 'h10) begin m_in[0] = 0; m_in[1] = 0; end
          if (d & 'h20) begin m_in[2] = 0; m_in[3] = 0; end
          m_ten = d & 7; m_rom = (d >> 7) & 1;
        end
        if (a == 'hF2) m_idx = d;
        if (a >= 'hF4 && a <= 'hF7) m_out[a - 'hF4] = d;
        if (a == 'hF8 || a == 'hF9) m_scr[a - 'hF8] = d;
        if (a >= 'hFA && a <= 'hFC) m_tgt[a - 'hFA] = d;
      end
    end
  end

  function automatic int exp_rd(int a);
    if (m_rom != 0 && a >= 'hFFC0) return romv(a & 63);
    if (a < 'hF0 || a > 'hFF) return ramv(a);
    case (a)
      'hF2: return m_idx;
      'hF3: return 128 | (m_idx & 127);
      'hF4, 'hF5, 'hF6, 'hF7: return m_in[a - 'hF4];
      'hF8, 'hF9: return m_scr[a - 'hF8];
      'hFD: return 'h11;
      'hFE: return 'h22;
      'hFF: return 'h33;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string rq, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  task automatic compare(string rq);
    int a;
    a = cpu_addr;
    if (cpu_rd) chk(rq, "cpu_rdata", cpu_rdata, exp_rd(a));
    chk(rq, "tmr_rd_pulse", tmr_rd_pulse,
        (cpu_rd && a >= 'hFD && a <= 'hFF) ? (1 << (a - 'hFD)) : 0);
    chk(rq, "ram_we", ram_we, (cpu_wr && m_wen != 0) ? 1 : 0);
    chk(rq, "dsp_we", dsp_we, (cpu_wr && a == 'hF3 && m_idx < 128) ? 1 : 0);
    chk(rq, "host_rdata", host_rdata, m_out[host_addr]);
    chk(rq, "dsp_addr", dsp_addr, m_idx & 127);
    chk(rq, "tmr_target", tmr_target, (m_tgt[2] << 16) | (m_tgt[1] << 8) | m_tgt[0]);
    chk(rq, "tmr_en", tmr_en, m_ten);
    chk(rq, "tmr_global_en", tmr_global_en, (m_run != 0 && m_halt == 0) ? 1 : 0);
    chk(rq, "speeds", {int_speed, ext_speed}, (m_is << 2) | m_es);
  endtask

  task automatic step(string rq, bit rd, bit wr, logic [15:0] a, logic [7:0] d = 0,
                      bit hw = 0, logic [1:0] ha = 0, logic [7:0] hd = 0);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    host_wr = hw; host_addr = ha; host_wdata = hd;
    ram_rdata = 8'(ramv(a));
    #1;
    compare(rq);
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0; host_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 5000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    step("R12", 1, 0, 16'h00F4);
    for (int k = 0; k < 4; k++) step("R12", 0, 0, 16'h1234, 0, 0, 2'(k));
    step("R12", 1, 0, 16'h00F8);
    // R2 overlay at reset
    step("R2", 1, 0, 16'hFFC0);
    step("R2", 1, 0, 16'hFFFF);
    step("R2", 1, 0, 16'hFFBF);
    // R1 window edges
    step("R1", 1, 0, 16'h00EF);
    step("R1", 1, 0, 16'h0100);
    step("R1", 1, 0, 16'h10F4);
    // R9 targets and counter reads
    step("R9", 0, 1, 16'h00FA, 8'h44);
    step("R9", 0, 1, 16'h00FB, 8'h55);
    step("R9", 0, 1, 16'h00FC, 8'h66);
    for (int k = 0; k < 3; k++) step("R9", 1, 0, 16'(16'h00FD + k));
    // R3 write-only registers read zero
    foreach (cpu_addr[i]) if (i < 1) begin end
    step("R3", 1, 0, 16'h00F0);
    step("R3", 1, 0, 16'h00F1);
    step("R3", 1, 0, 16'h00FA);
    step("R3", 1, 0, 16'h00FB);
    step("R3", 1, 0, 16'h00FC);
    // R10 scratch
    step("R10", 0, 1, 16'h00F8, 8'h5A);
    step("R10", 0, 1, 16'h00F9, 8'hA5);
    step("R10", 1, 0, 16'h00F8);
    step("R10", 1, 0, 16'h00F9);
    // R11 write-through at I/O and RAM addresses
    step("R11", 0, 1, 16'h0300, 8'h77);
    step("R11", 1, 0, 16'h0300);
    // R4 DSP port
    step("R4", 0, 1, 16'h00F2, 8'h05);
    step("R4", 1, 0, 16'h00F2);
    step("R4", 1, 0, 16'h00F3);
    step("R4", 0, 1, 16'h00F3, 8'h99);
    step("R4", 0, 1, 16'h00F2, 8'h85);
    step("R4", 1, 0, 16'h00F3);
    step("R4", 0, 1, 16'h00F3, 8'h99);
    // R5 mailbox: both latches behind one address
    for (int k = 0; k < 4; k++) step("R5", 0, 0, 16'h0000, 0, 1, 2'(k), 8'(8'hC0 + k));
    for (int k = 0; k < 4; k++) step("R5", 0, 1, 16'(16'h00F4 + k), 8'(8'h30 + k));
    for (int k = 0; k < 4; k++) step("R5", 1, 0, 16'(16'h00F4 + k), 0, 0, 2'(k));
    // R6 control register
    step("R6", 0, 1, 16'h00F1, 8'h90);
    for (int k = 0; k < 4; k++) step("R6", 1, 0, 16'(16'h00F4 + k));
    step("R6", 0, 1, 16'h00F1, 8'h27, 1, 2'd2, 8'hEE);
    step("R6", 1, 0, 16'h00F6);
    step("R6", 1, 0, 16'hFFC0);
    step("R6", 0, 1, 16'h00F1, 8'h80);
    step("R6", 1, 0, 16'hFFC5);
    // R7 test register with direct-page guard
    dp_flag = 1;
    step("R7", 0, 1, 16'h00F0, 8'hF1);
    step("R7", 1, 0, 16'h0000);
    dp_flag = 0;
    step("R7", 0, 1, 16'h00F0, 8'h5A);
    step("R7", 1, 0, 16'h0000);
    // R8 halt gate, R11 permit dropped then restored
    step("R8", 0, 1, 16'h00F0, 8'h09);
    step("R11", 0, 1, 16'h0200, 8'h3C);
    step("R11", 1, 0, 16'h0200);
    step("R8", 0, 1, 16'h00F0, 8'h02);
    step("R11", 0, 1, 16'h0200, 8'h3D);
    step("R11", 1, 0, 16'h0200);
    step("R8", 0, 1, 16'h00F0, 8'h0A);
    step("R8", 1, 0, 16'h00FE);
    finish_run();
  end
endmodule